// File: doc/BRIEF.md
# Baudot to ASCII Printer Decoder

This block sits between a processor's five-bit teleprinter output buffer and a character sink that takes seven-bit ASCII. The processor writes one five-bit code with a load pulse. The block latches the code and handles it in two steps. First it looks the code up. Then it either updates its letters/figures case state, or it offers the decoded character to the sink with a valid/ready handshake. When the code has been fully handled, the block raises a done flag. The processor polls that flag through a test pulse and a skip output.

The two case-change codes only switch the case state and print nothing. Every other code is translated through a 64-entry table. The table index has the case state as its top bit and the code as its five low bits. Some table entries are empty. An empty entry prints nothing but still completes the transfer. The sink may stall for any number of cycles. The character is held until the sink accepts it.

Top module: `baudot_print_decoder`

## Requirements
- R1: After reset the done flag is 0, char_valid_o is 0 and the case state is letters, so code 5'o01 prints 'T' (0x54).
- R2: In letters state a printable code is presented on char_o with char_valid_o high exactly two clock edges after the load edge. Examples: 5'o01 gives 0x54 'T', 5'o20 gives 0x45 'E', 5'o03 gives 0x4F 'O', 5'o04 gives 0x20 and 5'o10 gives 0x0A. done_o rises on the edge after the sink accepts.
- R3: Code 5'o33 switches to figures state. It emits no character and sets done_o two edges after the load edge. In figures state 5'o01 gives 0x35 '5' and 5'o12 gives 0x34 '4'.
- R4: Code 5'o37 switches to letters state. It emits no character and sets done_o two edges after the load edge.
- R5: A code whose table entry is zero emits no character and still sets done_o two edges after the load edge. Code 5'o00 in either state is such a code.
- R6: While char_ready_i is low, char_valid_o stays high, char_o stays stable and done_o stays 0.
- R7: A load pulse accepted while idle clears done_o on the next edge.
- R8: A clear pulse while idle clears done_o on the next edge.
- R9: skip_o is high only when test_i is high and done_o is 1.
- R10: A load pulse that arrives while a code is still being handled is ignored. No second character follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load pulse: latch code_i and start handling it |
| code_i | input | 5 | Five-bit Baudot code |
| clear_i | input | 1 | Pulse that clears the done flag |
| test_i | input | 1 | Test pulse for the skip output |
| done_o | output | 1 | Done flag |
| skip_o | output | 1 | High while test_i is high and done_o is set |
| char_o | output | 7 | Decoded ASCII character |
| char_valid_o | output | 1 | Character valid toward the sink |
| char_ready_i | input | 1 | Sink ready |

## Verification
A wrong case state stays hidden until the next non-shift code. It then shows as a wrong character on char_o, two edges after that code's load edge. For this reason the vectors mix shift codes with printable codes in both cases. A wrong done flag shows at once on skip_o during a test pulse. It also shows as a done edge one cycle early or late against the fixed two- and three-edge latencies, which the bench checks at every cycle of each transfer.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int CODE_W = 5;
  localparam int CHAR_W = 7;
  localparam int IDX_W  = CODE_W + 1;

  localparam logic [CODE_W-1:0] CODE_TO_FIG = 5'o33;
  localparam logic [CODE_W-1:0] CODE_TO_LTR = 5'o37;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_SEND = 2'd2
  } ctrl_st_e;
endpackage

// File: rtl/bdec_shift.sv
module bdec_shift
  import bdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [CODE_W-1:0] code,
  output logic              fig_o,
  output logic              is_shift_o
);
  logic fig_q, fig_d;
  logic hit_fig, hit_ltr;

  assign hit_fig    = (code == CODE_TO_FIG);
  assign hit_ltr    = (code == CODE_TO_LTR);
  assign is_shift_o = hit_fig | hit_ltr;

  always_comb begin
    fig_d = fig_q;
    if (upd_en && hit_fig) fig_d = 1'b1;
    if (upd_en && hit_ltr) fig_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fig_q <= 1'b0;
    else        fig_q <= fig_d;
  end

  assign fig_o = fig_q;
endmodule

// File: rtl/bdec_rom.sv
module bdec_rom
  import bdec_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [CHAR_W-1:0] ch
);
  always_comb begin
    case (idx)
      // letters half
      6'o01: ch = 7'h54;  6'o02: ch = 7'h0D;  6'o03: ch = 7'h4F;
      6'o04: ch = 7'h20;  6'o05: ch = 7'h48;  6'o06: ch = 7'h4E;
      6'o07: ch = 7'h4D;  6'o10: ch = 7'h0A;  6'o11: ch = 7'h4C;
      6'o12: ch = 7'h52;  6'o13: ch = 7'h47;  6'o14: ch = 7'h49;
      6'o15: ch = 7'h50;  6'o16: ch = 7'h43;  6'o17: ch = 7'h56;
      6'o20: ch = 7'h45;  6'o21: ch = 7'h5A;  6'o22: ch = 7'h44;
      6'o23: ch = 7'h42;  6'o24: ch = 7'h53;  6'o25: ch = 7'h59;
      6'o26: ch = 7'h46;  6'o27: ch = 7'h58;  6'o30: ch = 7'h41;
      6'o31: ch = 7'h57;  6'o32: ch = 7'h4A;  6'o34: ch = 7'h55;
      6'o35: ch = 7'h51;  6'o36: ch = 7'h4B;
      // figures half
      6'o41: ch = 7'h35;  6'o42: ch = 7'h0D;  6'o43: ch = 7'h39;
      6'o44: ch = 7'h20;  6'o45: ch = 7'h23;  6'o46: ch = 7'h2C;
      6'o47: ch = 7'h2E;  6'o50: ch = 7'h0A;  6'o51: ch = 7'h29;
      6'o52: ch = 7'h34;  6'o53: ch = 7'h26;  6'o54: ch = 7'h38;
      6'o55: ch = 7'h30;  6'o56: ch = 7'h3A;  6'o57: ch = 7'h3B;
      6'o60: ch = 7'h33;  6'o61: ch = 7'h22;  6'o62: ch = 7'h24;
      6'o63: ch = 7'h3F;  6'o64: ch = 7'h07;  6'o65: ch = 7'h36;
      6'o66: ch = 7'h21;  6'o67: ch = 7'h2F;  6'o70: ch = 7'h2D;
      6'o71: ch = 7'h32;  6'o72: ch = 7'h27;  6'o74: ch = 7'h37;
      6'o75: ch = 7'h31;  6'o76: ch = 7'h28;
      default: ch = '0;
    endcase
  end
endmodule

// File: rtl/bdec_ctrl.sv
module bdec_ctrl
  import bdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic              is_shift_i,
  input  logic [CHAR_W-1:0] rom_char_i,
  input  logic              ready_i,
  output ctrl_st_e          state_o,
  output logic              take_o,
  output logic              look_o,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              done_o
);
  ctrl_st_e          st_q, st_d;
  logic              done_q, done_d;
  logic [CHAR_W-1:0] char_q, char_d;
  logic              char_en;
  logic              silent;

  assign take_o  = load_i && (st_q == ST_IDLE);
  assign look_o  = (st_q == ST_LOOK);
  assign silent  = is_shift_i || (rom_char_i == '0);
  assign char_en = look_o && !silent;

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    char_d = char_q;
    case (st_q)
      ST_IDLE: begin
        if (take_o) begin
          st_d   = ST_LOOK;
          done_d = 1'b0;
        end else if (clear_i) begin
          done_d = 1'b0;
        end
      end
      ST_LOOK: begin
        if (silent) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (ready_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (char_en) char_d = rom_char_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       char_q <= '0;
    else if (char_en) char_q <= char_d;
  end

  assign state_o = st_q;
  assign valid_o = (st_q == ST_SEND);
  assign char_o  = char_q;
  assign done_o  = done_q;
endmodule

// File: rtl/baudot_print_decoder.sv
module baudot_print_decoder
  import bdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clear_i,
  input  logic              test_i,
  output logic              done_o,
  output logic              skip_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_valid_o,
  input  logic              char_ready_i
);
  logic [CODE_W-1:0] code_q;
  logic              take;
  logic              look;
  logic              fig;
  logic              is_shift;
  logic [CHAR_W-1:0] rom_char;
  ctrl_st_e          ctrl_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (take) code_q <= code_i;
  end

  bdec_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (look),
    .code       (code_q),
    .fig_o      (fig),
    .is_shift_o (is_shift)
  );

  bdec_rom u_rom (
    .idx (({fig, code_q})),
    .ch  (rom_char)
  );

  bdec_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .clear_i    (clear_i),
    .is_shift_i (is_shift),
    .rom_char_i (rom_char),
    .ready_i    (char_ready_i),
    .state_o    (ctrl_st),
    .take_o     (take),
    .look_o     (look),
    .valid_o    (char_valid_o),
    .char_o     (char_o),
    .done_o     (done_o)
  );

  assign skip_o = test_i && done_o;
endmodule

// File: rtl/bdec_chk.sv
module bdec_chk
  import bdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              clear_i,
  input logic              skip_o,
  input logic              done_o,
  input logic              valid_o,
  input logic              ready_i,
  input logic [CHAR_W-1:0] char_o,
  input ctrl_st_e          st,
  input logic              look_shift
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(char_o)); // R6

  AST_NO_DONE_WHILE_OFFERING: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !done_o); // R6

  AST_ACCEPT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i |=> done_o && !valid_o); // R2

  AST_SHIFT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOK) && look_shift |=> done_o && !valid_o); // R3

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (st == ST_IDLE) |=> !done_o); // R7

  AST_CLEAR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && (st == ST_IDLE) |=> !done_o); // R8

  AST_SKIP_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> done_o); // R9
endmodule

bind baudot_print_decoder bdec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .clear_i    (clear_i),
  .skip_o     (skip_o),
  .done_o     (done_o),
  .valid_o    (char_valid_o),
  .ready_i    (char_ready_i),
  .char_o     (char_o),
  .st         (ctrl_st),
  .look_shift (is_shift)
);

// File: tb/baudot_print_decoder_test.sv
`timescale 1ns/1ps
module baudot_print_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i, clear_i, test_i, char_ready_i;
  logic [4:0] code_i;
  logic       done_o, skip_o, char_valid_o;
  logic [6:0] char_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  baudot_print_decoder uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .code_i       (code_i),
    .clear_i      (clear_i),
    .test_i       (test_i),
    .done_o       (done_o),
    .skip_o       (skip_o),
    .char_o       (char_o),
    .char_valid_o (char_valid_o),
    .char_ready_i (char_ready_i)
  );

  // {code, emits, char}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {5'o01, 1'b1, 7'h54},   // R2 'T'
    {5'o20, 1'b1, 7'h45},   // R2 'E'
    {5'o33, 1'b0, 7'h00},   // R3 to figures
    {5'o01, 1'b1, 7'h35},   // R3 '5'
    {5'o12, 1'b1, 7'h34},   // R3 '4'
    {5'o00, 1'b0, 7'h00},   // R5 empty entry
    {5'o37, 1'b0, 7'h00},   // R4 to letters
    {5'o03, 1'b1, 7'h4F},   // R4 'O'
    {5'o04, 1'b1, 7'h20},   // R2 space
    {5'o10, 1'b1, 7'h0A}    // R2 line feed
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Pulse load at a negedge, then inspect the four following negedges.
  task automatic run_code(input logic [4:0] c, input bit emit, input logic [6:0] ch, input string req);
    code_i = c;
    load_i = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      load_i = 1'b0;
      chk(char_valid_o == (emit && k == 2), req, char_valid_o, emit && k == 2);
      if (emit && k == 2) chk(char_o == ch, req, char_o, ch);
      chk(done_o == (k >= (emit ? 3 : 2)), {req, " done/R7"}, done_o, k >= (emit ? 3 : 2));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; clear_i = 1'b0; test_i = 1'b0;
    char_ready_i = 1'b1; code_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(done_o == 1'b0, "R1", done_o, 0);
    chk(char_valid_o == 1'b0, "R1", char_valid_o, 0);
    test_i = 1'b1; #1;
    chk(skip_o == 1'b0, "R9", skip_o, 0);
    test_i = 1'b0;

    for (int i = 0; i < NV; i++)
      run_code(VEC[i][12:8], VEC[i][7], VEC[i][6:0], "R2/R3/R4/R5");

    // R9 skip follows done
    test_i = 1'b1; #1;
    chk(skip_o == 1'b1, "R9", skip_o, 1);
    test_i = 1'b0; #1;
    chk(skip_o == 1'b0, "R9", skip_o, 0);

    // R8 clear pulse
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    chk(done_o == 1'b0, "R8", done_o, 0);
    test_i = 1'b1; #1;
    chk(skip_o == 1'b0, "R9", skip_o, 0);
    test_i = 1'b0;

    // R6 backpressure, R10 load while busy
    char_ready_i = 1'b0;
    code_i = 5'o20; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
    @(negedge clk);
    code_i = 5'o01; load_i = 1'b1;   // ignored: block is busy
    @(negedge clk); load_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(char_valid_o == 1'b1, "R6", char_valid_o, 1);
      chk(char_o == 7'h45, "R6", char_o, 7'h45);
      chk(done_o == 1'b0, "R6", done_o, 0);
      @(negedge clk);
    end
    char_ready_i = 1'b1;
    @(negedge clk);
    chk(char_valid_o == 1'b0, "R6", char_valid_o, 0);
    chk(done_o == 1'b1, "R6", done_o, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(char_valid_o == 1'b0, "R10", char_valid_o, 0);
      chk(done_o == 1'b1, "R10", done_o, 1);
    end

    // R1 reset returns to letters
    run_code(5'o33, 1'b0, 7'h00, "R3");
    rst_n = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R1", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_code(5'o01, 1'b1, 7'h54, "R1");

    summary();
  end
endmodule